// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

A single counter channel that serves both as a PWM generator and as a general interval timer. A 24-bit counter advances once per bus clock while the channel runs. Two compare points are held in registers. The *mid point* places the rising edge of the PWM output within the period. The *end point* closes the period, and the counter then returns to zero. Either compare can raise the one shared interrupt status flag, and each compare has its own enable under a common interrupt enable.

Software reaches the channel through a small register port. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_sel`. Software can read the counter while the channel runs and turn the count into elapsed time. A one-shot mode stops the channel after one period. A counter-hold bit and a status-clear bit are each used by writing 1 and then 0.

Top module: `pwm_cmp_timer`

## Requirements
- R1: `bus_sel` selects a register: 0 counter, 1 mid point, 2 end point, 3 control. The counter, mid and end registers are 24 bits wide. Written bits above bit 23 are dropped, and those bits read back as zero.
- R2: When control bit 0 (run) is 1 and control bit 7 (hold) is 0, the counter increments on every clock. In a cycle where it equals the end point, the next value is 0, so one period lasts end+1 clocks. The full range up to 0xFFFFFF is usable.
- R3: `pwm_out` equals control bit 3 (output enable) AND (counter >= mid point). It is therefore low from zero up to the mid point and high from the mid point to the end of the period.
- R4: The status flag sets only while the channel runs, in either of two cases. The counter equals the mid point with bits 10 (mid enable) and 5 (interrupt enable) both set. Or the counter equals the end point with bits 11 (end enable) and 5 both set. Otherwise it does not set.
- R5: `irq` equals the status flag AND control bit 5. It stays high until software clears the flag.
- R6: The status flag reads as control bit 6. A control write with bit 6 = 1 clears it. A control write with bit 6 = 0 leaves it unchanged. A new match in the same cycle as the clearing write leaves it set.
- R7: While control bit 7 (hold) is 1, the counter is forced to 0 and no match occurs. After bit 7 is written back to 0, counting restarts from 0.
- R8: When control bit 4 (one-shot) is 1, the end-point match clears run bit 0 in the same edge that returns the counter to 0. The counter then stays at 0.
- R9: Writing 0 to the control register stops the channel. The counter holds its value, and `pwm_out` and `irq` go low.
- R10: After reset, all registers read 0 and `pwm_out` and `irq` are low.
- R11: A write to the counter register loads the value, and this load takes priority over counting, holding and wrapping in that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter ticks on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_sel` |
| pwm_out | output | 1 | PWM output level |
| irq | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach from the ports is a match on the same edge as a control write. Examples are the end-point match that lands just as software clears the status flag, and the one-shot stop edge. The bench keeps a cycle-exact count of the counter after every write, so it knows the counter value at each edge. It then issues writes at chosen offsets within the period, so a clear lands one cycle before an end-point match. A full sweep over every mid/end pair up to an end point of 6 checks the counter and the PWM level on every cycle of two periods.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int CB_RUN  = 0;
   localparam int CB_OUT  = 3;
   localparam int CB_ONE  = 4;
   localparam int CB_IEN  = 5;
   localparam int CB_STAT = 6;
   localparam int CB_HOLD = 7;
   localparam int CB_MIE  = 10;
   localparam int CB_EIE  = 11;
   localparam int CB_TOP  = 11;

   typedef enum logic [1:0] {
      SEL_CNT = 2'd0,
      SEL_MID = 2'd1,
      SEL_END = 2'd2,
      SEL_CTL = 2'd3
   } sel_e;

   typedef struct packed {
      logic run_en;
      logic out_en;
      logic one_shot;
      logic irq_en;
      logic cnt_hold;
      logic mid_ie;
      logic end_ie;
   } ctl_t;
endpackage

// File: rtl/pwmt_core.sv
module pwmt_core #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             run_en,
   input  logic             cnt_hold,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] mid_q,
   output logic [CNT_W-1:0] end_q,
   output logic [1:0]       hit
);
   import pwmt_pkg::*;

   localparam int NCMP = 2;

   logic             running;
   logic             cnt_wr;
   logic [CNT_W-1:0] ref_w [NCMP];
   logic             hit_u [NCMP];

   assign running = run_en & ~cnt_hold;
   assign cnt_wr  = wr_en & (wr_sel == SEL_CNT);

   // compare slot g sits at select g+1 (mid, then end)
   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      logic [CNT_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= '0;
         else if (wr_en && (wr_sel == 2'(g + 1)))
            r_q <= wr_data;
      end
      assign ref_w[g] = r_q;
      assign hit_u[g] = running && (cnt_q == r_q);
   end

   assign mid_q = ref_w[0];
   assign end_q = ref_w[1];
   assign hit   = {hit_u[1], hit_u[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_wr)
         cnt_q <= wr_data;
      else if (cnt_hold)
         cnt_q <= '0;
      else if (run_en)
         cnt_q <= hit_u[1] ? '0 : cnt_q + 1'b1;
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !hit_u[1] && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (running && hit_u[1] && !cnt_wr) |=> cnt_q == '0);
   assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_hold && !cnt_wr) |=> cnt_q == '0);
   assert_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !cnt_hold && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/pwmt_ctl.sv
module pwmt_ctl (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr,
   input  pwmt_pkg::ctl_t  ctl_in,
   input  logic            stat_clr,
   input  logic [1:0]      hit,
   output pwmt_pkg::ctl_t  ctl_q,
   output logic            status_q
);
   import pwmt_pkg::*;

   logic set_evt;

   assign set_evt = ctl_q.irq_en &
                    ((ctl_q.mid_ie & hit[0]) | (ctl_q.end_ie & hit[1]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_wr)
         ctl_q <= ctl_in;
      else if (ctl_q.one_shot && hit[1])
         ctl_q.run_en <= 1'b0;
   end

   // a match in the clearing cycle wins so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 1'b0;
      else if (set_evt)
         status_q <= 1'b1;
      else if (ctl_wr && stat_clr)
         status_q <= 1'b0;
   end

   assert_stat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !(ctl_wr && stat_clr)) |=> status_q);
   assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.irq_en |=> !$rose(status_q));
   assert_oneshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.one_shot && hit[1] && !ctl_wr) |=> !ctl_q.run_en);
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer #(
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out,
   output logic              irq
);
   import pwmt_pkg::*;

   localparam int PAD_W = DATA_W - CNT_W;

   if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cnt_w
      $error("pwm_cmp_timer: CNT_W must be in 2..DATA_W-1");
   end
   if (DATA_W <= CB_TOP) begin : g_bad_data_w
      $error("pwm_cmp_timer: DATA_W too small for control fields");
   end

   ctl_t             ctl_in;
   ctl_t             ctl_q;
   logic             status_q;
   logic             ctl_wr;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mid_q;
   logic [CNT_W-1:0] end_q;
   logic [1:0]       hit;
   logic [DATA_W-1:0] ctl_word;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign ctl_wr = bus_we & (bus_sel == SEL_CTL);

   always_comb begin
      ctl_in.run_en   = bus_wdata[CB_RUN];
      ctl_in.out_en   = bus_wdata[CB_OUT];
      ctl_in.one_shot = bus_wdata[CB_ONE];
      ctl_in.irq_en   = bus_wdata[CB_IEN];
      ctl_in.cnt_hold = bus_wdata[CB_HOLD];
      ctl_in.mid_ie   = bus_wdata[CB_MIE];
      ctl_in.end_ie   = bus_wdata[CB_EIE];
   end

   pwmt_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we),
      .wr_sel   (bus_sel),
      .wr_data  (bus_wdata[CNT_W-1:0]),
      .run_en   (ctl_q.run_en),
      .cnt_hold (ctl_q.cnt_hold),
      .cnt_q    (cnt_q),
      .mid_q    (mid_q),
      .end_q    (end_q),
      .hit      (hit)
   );

   pwmt_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_in   (ctl_in),
      .stat_clr (bus_wdata[CB_STAT]),
      .hit      (hit),
      .ctl_q    (ctl_q),
      .status_q (status_q)
   );

   always_comb begin
      ctl_word          = '0;
      ctl_word[CB_RUN]  = ctl_q.run_en;
      ctl_word[CB_OUT]  = ctl_q.out_en;
      ctl_word[CB_ONE]  = ctl_q.one_shot;
      ctl_word[CB_IEN]  = ctl_q.irq_en;
      ctl_word[CB_STAT] = status_q;
      ctl_word[CB_HOLD] = ctl_q.cnt_hold;
      ctl_word[CB_MIE]  = ctl_q.mid_ie;
      ctl_word[CB_EIE]  = ctl_q.end_ie;
   end

   always_comb begin
      unique case (bus_sel)
         SEL_CNT: bus_rdata = {{PAD_W{1'b0}}, cnt_q};
         SEL_MID: bus_rdata = {{PAD_W{1'b0}}, mid_q};
         SEL_END: bus_rdata = {{PAD_W{1'b0}}, end_q};
         default: bus_rdata = ctl_word;
      endcase
   end

   assign pwm_out = ctl_q.out_en & (cnt_q >= mid_q);
   assign irq     = status_q & ctl_q.irq_en;

   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ctl_wr) |=> irq);
   assert_pwm_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.out_en |-> !pwm_out);
endmodule

// File: tb/pwm_cmp_timer_tb.sv
module pwm_cmp_timer_tb;
   localparam int RUN = 1, OUT = 8, ONE = 16, IEN = 32, STAT = 64,
                  HOLD = 128, MIE = 1024, EIE = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;
   logic        irq;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   pwm_cmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out), .irq(irq)
   );

   task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", r, a, e);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_sel = s; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      bus_sel = s;
      #1;
      v = bus_rdata;
   endtask

   task automatic clear_stat();
      wr(3, 0); wr(3, STAT); wr(3, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         rd(2'(s), v);
         chk("R10 reg", v, 0);
      end
      chk("R10 pwm", {31'd0, pwm_out}, 0);
      chk("R10 irq", {31'd0, irq}, 0);

      // R2/R3 sweep over all mid/end pairs
      for (int L = 0; L < 7; L++) begin
         for (int H = 0; H <= L; H++) begin
            wr(3, 0); wr(0, 0); wr(1, H); wr(2, L); wr(3, RUN | OUT);
            for (int k = 0; k <= 2 * (L + 1); k++) begin
               int e;
               if (k > 0) @(negedge clk);
               e = k % (L + 1);
               rd(0, v);
               chk("R2 count", v, e);
               chk("R3 pwm", {31'd0, pwm_out}, (e >= H) ? 1 : 0);
            end
         end
      end

      // R4 mid-point interrupt
      clear_stat();
      wr(0, 0); wr(1, 2); wr(2, 5); wr(3, RUN | IEN | MIE);
      for (int k = 0; k <= 8; k++) begin
         if (k > 0) @(negedge clk);
         chk("R4/R5 mid irq", {31'd0, irq}, (k >= 3) ? 1 : 0);
      end

      // R4 end-point interrupt only, mid match must not set
      clear_stat();
      wr(0, 0); wr(1, 1); wr(2, 4); wr(3, RUN | IEN | EIE);
      for (int k = 0; k <= 7; k++) begin
         if (k > 0) @(negedge clk);
         chk("R4 end irq", {31'd0, irq}, (k >= 5) ? 1 : 0);
      end
      // R6 clear just before the next end match
      wr(3, RUN | IEN | EIE | STAT);
      rd(3, v);
      chk("R6 stat cleared", v & STAT, 0);
      chk("R6 irq low", {31'd0, irq}, 0);
      wr(3, RUN | IEN | EIE);
      chk("R6 re-set by match", {31'd0, irq}, 1);
      rd(3, v);
      chk("R6 stat read", v, RUN | IEN | EIE | STAT);

      // R4 global enable gates both sources
      clear_stat();
      wr(0, 0); wr(1, 1); wr(2, 3); wr(3, RUN | MIE | EIE);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk("R4 gated irq", {31'd0, irq}, 0);
      end
      rd(3, v);
      chk("R4 gated stat", v & STAT, 0);

      // R8 one-shot
      clear_stat();
      wr(0, 0); wr(1, 1); wr(2, 3); wr(3, RUN | ONE | IEN | EIE);
      for (int k = 0; k <= 7; k++) begin
         if (k > 0) @(negedge clk);
         if (k == 4) begin
            rd(3, v);
            chk("R8 ctl after shot", v, ONE | IEN | EIE | STAT);
         end else begin
            rd(0, v);
            chk("R8 count", v, (k <= 3) ? k : 0);
         end
         chk("R8 irq", {31'd0, irq}, (k >= 4) ? 1 : 0);
      end

      // R7 counter hold
      wr(3, 0); wr(0, 0); wr(1, 0); wr(2, 9); wr(3, RUN);
      repeat (3) @(negedge clk);
      wr(3, RUN | HOLD);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         rd(0, v);
         chk("R7 held", v, 0);
      end
      wr(3, RUN);
      for (int k = 0; k <= 2; k++) begin
         if (k > 0) @(negedge clk);
         rd(0, v);
         chk("R7 resume", v, k);
      end

      // R9 stop by writing zero
      wr(3, 0);
      for (int k = 0; k < 3; k++) begin
         if (k > 0) @(negedge clk);
         rd(0, v);
         chk("R9 held count", v, 4);
         chk("R9 pwm", {31'd0, pwm_out}, 0);
         chk("R9 irq", {31'd0, irq}, 0);
      end
      wr(3, OUT);
      chk("R3 out enabled", {31'd0, pwm_out}, 1);

      // R1 upper bits dropped
      wr(2, 32'hFF00_0007);
      rd(2, v);
      chk("R1 end upper", v, 32'h0000_0007);
      wr(0, 32'hAB12_3456);
      rd(0, v);
      chk("R1 cnt upper", v, 32'h0012_3456);
      wr(1, 32'hFFFF_FFFF);
      rd(1, v);
      chk("R1 mid upper", v, 32'h00FF_FFFF);

      // R11 load while running
      wr(2, 100); wr(3, RUN); wr(0, 50);
      rd(0, v);
      chk("R11 load", v, 50);
      @(negedge clk);
      rd(0, v);
      chk("R11 continue", v, 51);

      // R2 full range boundary
      wr(3, 0); wr(2, 32'h00FF_FFFF); wr(0, 32'h00FF_FFFE); wr(3, RUN);
      for (int k = 0; k <= 2; k++) begin
         if (k > 0) @(negedge clk);
         rd(0, v);
         chk("R2 max wrap", v, (k == 0) ? 32'hFF_FFFE : (k == 1) ? 32'hFF_FFFF : 0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule